// File: doc/BRIEF.md
# External Bus Wait-State Controller

This block sequences a single access on an external bus through a fixed run of bus states. An access begins with T1 and continues with T2. It then takes zero or more wait states (TW) and ends with T3, after which the block returns to idle. The number of wait states depends on two inputs: a wait count and a wait-policy setting. Some policies also depend on an active-low wait input sampled from the bus.

Three policies are supported:
- **Program:** the fixed count is inserted every time.
- **Pin:** the fixed count is inserted, and a held-low wait input can then stretch the access without limit.
- **Auto:** the fixed count is inserted only when the wait input is low at the end of T2, and never more than that count.

The block reports the current bus state on a 3-bit code and raises a one-cycle completion flag during T3. Every sample is taken on the rising edge of `clk`. That edge stands for the falling edge of the system clock at which the bus signals are meant to be sampled.

Top module: `ext_bus_waitctl`

## Requirements
- R1: While `rst_n` is low and on the first cycle after its release, `bus_state_o` is idle and `cycle_done_o` is low.
- R2: From idle, `acc_req_i` high moves the block to T1 on the next cycle, and T2 always follows T1. `acc_req_i` is ignored in every state other than idle, so a request held high through an access leaves exactly one idle cycle after T3 before the next T1.
- R3: With `wait_mode_i` = 2'b00 (program) or 2'b11 (treated as program), exactly `wait_cnt_i` TW states are inserted between T2 and T3, whatever `wait_n_i` does.
- R4: With `wait_mode_i` = 2'b01 (pin), `wait_cnt_i` TW states are always inserted first. After that, every time `wait_n_i` is sampled low at the end of the last T2 or last TW, one more TW follows. With a count of 0, the sample is taken at the end of T2 itself.
- R5: With `wait_mode_i` = 2'b10 (auto), `wait_cnt_i` TW states are inserted when `wait_n_i` is low at the end of T2, and none otherwise. A wait input held low never extends the access past the count.
- R6: T3 lasts one cycle and is always followed by idle.
- R7: `cycle_done_o` is high exactly in the cycles in which `bus_state_o` shows T3.
- R8: `wait_cnt_i` and `wait_mode_i` are sampled in the cycle the request is accepted. Changes to them during the access have no effect on that access.
- R9: `bus_state_o` encodes idle as 0, T1 as 1, T2 as 2, TW as 3 and T3 as 4, and no other value appears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock (falling edge of the system clock) |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_req_i | input | 1 | Request to start an external access |
| wait_cnt_i | input | WC_W | Programmed number of wait states |
| wait_mode_i | input | 2 | Wait policy: 00 program, 01 pin, 10 auto, 11 program |
| wait_n_i | input | 1 | Active-low wait input from the bus |
| bus_state_o | output | 3 | Current bus state code |
| cycle_done_o | output | 1 | High during T3 |

## Verification
The assertions assume that `wait_n_i`, `acc_req_i` and the configuration inputs are settled at each sampling edge. They also assume the block sees no reset in the middle of an access that it would need to resume.

The stimulus changes every input only half a period away from the sampling edge. It drives `wait_n_i` from the reference model's own count of wait states, so the wait input goes low and high at chosen points: before T2, partway through the programmed waits, and beyond them. Configuration changes are made only after a request has been accepted, which exercises the capture rule without breaking the stability assumption.

// File: rtl/waitctl_pkg.sv
// Shared types for the external bus wait-state controller.
// Assumes a 3-bit state code and a 2-bit wait-policy code.
package waitctl_pkg;

    typedef enum logic [2:0] {
        BS_IDLE = 3'd0,
        BS_T1   = 3'd1,
        BS_T2   = 3'd2,
        BS_TW   = 3'd3,
        BS_T3   = 3'd4
    } bus_state_e;

    typedef enum logic [1:0] {
        WM_PROG = 2'd0,
        WM_PIN  = 2'd1,
        WM_AUTO = 2'd2,
        WM_RSVD = 2'd3
    } wait_mode_e;

    // Map the reserved policy code onto program wait.
    function automatic wait_mode_e norm_mode(input logic [1:0] raw);
        if (raw == 2'd3) begin
            return WM_PROG;
        end
        return wait_mode_e'(raw);
    endfunction

endpackage

// File: rtl/waitctl_cfg_latch.sv
// Holds the wait count and wait policy for the access in progress.
// Loads only when capture_i is high, which the sequencer raises on
// request acceptance. Reset gives count all-ones and program policy.
module waitctl_cfg_latch
    import waitctl_pkg::*;
#(
    parameter int WC_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture_i,
    input  logic [WC_W-1:0]  wc_i,
    input  logic [1:0]       mode_i,
    output logic [WC_W-1:0]  wc_o,
    output wait_mode_e       mode_o
);

    // Capture the configuration at acceptance and hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wc_o   <= '1;
            mode_o <= WM_PROG;
        end else if (capture_i) begin
            wc_o   <= wc_i;
            mode_o <= norm_mode(mode_i);
        end
    end

endmodule

// File: rtl/waitctl_tw_counter.sv
// Counts the programmed wait states still to run after the current one.
// Loaded while in T2 and decremented in each TW that is not the last
// programmed one. last_o is high when no programmed wait remains.
module waitctl_tw_counter #(
    parameter int WC_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [WC_W-1:0]  load_val_i,
    input  logic             dec_i,
    output logic             last_o
);

    localparam logic [WC_W-1:0] ONE = {{(WC_W-1){1'b0}}, 1'b1};

    logic [WC_W-1:0] rem_q;

    // Load the remaining-wait count or step it down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= '0;
        end else if (load_i) begin
            rem_q <= load_val_i;
        end else if (dec_i) begin
            rem_q <= rem_q - ONE;
        end
    end

    // Flag the final programmed wait.
    always_comb begin
        last_o = (rem_q == '0);
    end

endmodule

// File: rtl/waitctl_seq.sv
// Bus-state sequencer: idle, T1, T2, TW, T3. It decides at the end of
// T2 and of each TW whether another wait is due, from the captured
// count, the captured policy and the wait input. The done flag is
// registered from the next state so that it lines up with T3.
module waitctl_seq
    import waitctl_pkg::*;
#(
    parameter int WC_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  logic             wait_n_i,
    input  logic [WC_W-1:0]  wc_i,
    input  wait_mode_e       mode_i,
    input  logic             last_i,
    output bus_state_e       state_o,
    output logic             done_o,
    output logic             capture_o,
    output logic             load_o,
    output logic [WC_W-1:0]  load_val_o,
    output logic             dec_o
);

    localparam logic [WC_W-1:0] ONE = {{(WC_W-1){1'b0}}, 1'b1};

    bus_state_e nxt;
    logic       pin_hold;
    logic       have_prog;

    // Policy-dependent helpers for the wait decision.
    always_comb begin
        pin_hold  = (mode_i == WM_PIN) && !wait_n_i;
        have_prog = (wc_i != '0);
    end

    // Next-state decision.
    always_comb begin
        nxt = state_o;
        unique case (state_o)
            BS_IDLE: if (req_i) nxt = BS_T1;
            BS_T1:   nxt = BS_T2;
            BS_T2: begin
                if (have_prog) begin
                    nxt = ((mode_i == WM_AUTO) && wait_n_i) ? BS_T3 : BS_TW;
                end else begin
                    nxt = pin_hold ? BS_TW : BS_T3;
                end
            end
            BS_TW: begin
                if (!last_i || pin_hold) nxt = BS_TW;
                else                     nxt = BS_T3;
            end
            BS_T3:   nxt = BS_IDLE;
            default: nxt = BS_IDLE;
        endcase
    end

    // Control strobes for the config latch and wait counter.
    always_comb begin
        capture_o  = (state_o == BS_IDLE) && req_i;
        load_o     = (state_o == BS_T2);
        load_val_o = have_prog ? (wc_i - ONE) : '0;
        dec_o      = (state_o == BS_TW) && !last_i;
    end

    // State and done registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_o <= BS_IDLE;
            done_o  <= 1'b0;
        end else begin
            state_o <= nxt;
            done_o  <= (nxt == BS_T3);
        end
    end

endmodule

// File: rtl/ext_bus_waitctl.sv
// Top level of the external bus wait-state controller. It ties together
// the config latch, the wait counter and the sequencer. It assumes all
// inputs are settled at the rising edge of clk, which stands for the
// sampling edge on the bus.
module ext_bus_waitctl
    import waitctl_pkg::*;
#(
    parameter int WC_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_req_i,
    input  logic [WC_W-1:0]  wait_cnt_i,
    input  logic [1:0]       wait_mode_i,
    input  logic             wait_n_i,
    output logic [2:0]       bus_state_o,
    output logic             cycle_done_o
);

    logic [WC_W-1:0] wc_q;
    wait_mode_e      mode_q;
    logic            capture;
    logic            load;
    logic [WC_W-1:0] load_val;
    logic            dec;
    logic            last;
    bus_state_e      state;

    waitctl_cfg_latch #(.WC_W(WC_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture_i (capture),
        .wc_i      (wait_cnt_i),
        .mode_i    (wait_mode_i),
        .wc_o      (wc_q),
        .mode_o    (mode_q)
    );

    waitctl_tw_counter #(.WC_W(WC_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load),
        .load_val_i (load_val),
        .dec_i      (dec),
        .last_o     (last)
    );

    waitctl_seq #(.WC_W(WC_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (acc_req_i),
        .wait_n_i   (wait_n_i),
        .wc_i       (wc_q),
        .mode_i     (mode_q),
        .last_i     (last),
        .state_o    (state),
        .done_o     (cycle_done_o),
        .capture_o  (capture),
        .load_o     (load),
        .load_val_o (load_val),
        .dec_o      (dec)
    );

    // Present the state code on the port.
    always_comb begin
        bus_state_o = state;
    end

endmodule

// File: rtl/waitctl_chk.sv
// Property checker for ext_bus_waitctl, attached by bind. It counts the
// wait states of each access in a saturating counter and checks them
// against the captured configuration when T3 is reached.
module waitctl_chk #(
    parameter int WC_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  logic             wait_n_i,
    input  logic [2:0]       state,
    input  logic             done,
    input  logic [WC_W-1:0]  wc_q,
    input  logic [1:0]       mode_q
);

    logic [15:0] tw_run;
    logic        is_prog;

    // Count the TW states of the current access, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tw_run <= '0;
        end else if (state == 3'd2) begin
            tw_run <= '0;
        end else if (state == 3'd3 && tw_run != 16'hFFFF) begin
            tw_run <= tw_run + 16'd1;
        end
    end

    // Captured policy that behaves as program wait.
    always_comb begin
        is_prog = (mode_q == 2'd0) || (mode_q == 2'd3);
    end

    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (state == 3'd0 && !done)); // R1
    AST_ACCEPT_T1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 3'd0 && req_i) |=> state == 3'd1); // R2
    AST_T1_THEN_T2: assert property (@(posedge clk) disable iff (!rst_n)
        state == 3'd1 |=> state == 3'd2); // R2
    AST_PROG_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 3'd4 && is_prog) |-> tw_run == 16'(wc_q)); // R3
    AST_PIN_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 3'd4 && mode_q == 2'd1) |-> tw_run >= 16'(wc_q)); // R4
    AST_PIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 3'd3 && mode_q == 2'd1 && !wait_n_i) |=> state == 3'd3); // R4
    AST_AUTO_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 3'd4 && mode_q == 2'd2) |-> (tw_run == 16'd0 || tw_run == 16'(wc_q))); // R5
    AST_AUTO_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 3'd2 && mode_q == 2'd2 && wait_n_i) |=> state == 3'd4); // R5
    AST_T3_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        state == 3'd4 |=> state == 3'd0); // R6
    AST_DONE_IN_T3: assert property (@(posedge clk) disable iff (!rst_n)
        done == (state == 3'd4)); // R7
    AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        state != 3'd0 |=> ($stable(wc_q) && $stable(mode_q))); // R8
    AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        state <= 3'd4); // R9

endmodule

bind ext_bus_waitctl waitctl_chk #(.WC_W(WC_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_i    (acc_req_i),
    .wait_n_i (wait_n_i),
    .state    (bus_state_o),
    .done     (cycle_done_o),
    .wc_q     (wc_q),
    .mode_q   (mode_q)
);

// File: tb/ext_bus_waitctl_bench.sv
module ext_bus_waitctl_bench;

    localparam int WC_W = 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            acc_req_i = 1'b0;
    logic [WC_W-1:0] wait_cnt_i = '0;
    logic [1:0]      wait_mode_i = 2'd0;
    logic            wait_n_i = 1'b1;
    logic [2:0]      bus_state_o;
    logic            cycle_done_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // Reference model state.
    int m_state = 0;
    int m_wc = 0;
    int m_mode = 0;
    int m_tw = 0;
    int m_target = 0;
    int hold = 0;

    // Per-access expectation.
    int obs_tw = 0;
    int exp_tw = 0;
    string tag = "R3";

    always #4 clk = ~clk;

    ext_bus_waitctl #(.WC_W(WC_W)) u_ext_bus_waitctl (
        .clk          (clk),
        .rst_n        (rst_n),
        .acc_req_i    (acc_req_i),
        .wait_cnt_i   (wait_cnt_i),
        .wait_mode_i  (wait_mode_i),
        .wait_n_i     (wait_n_i),
        .bus_state_o  (bus_state_o),
        .cycle_done_o (cycle_done_o)
    );

    // Behavioural model, advanced at each sampling edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0;
        end else begin
            case (m_state)
                0: if (acc_req_i) begin
                    m_wc = int'(wait_cnt_i);
                    m_mode = (wait_mode_i == 2'd3) ? 0 : int'(wait_mode_i);
                    m_state = 1;
                end
                1: begin
                    m_state = 2;
                    m_tw = 0;
                end
                2, 3: begin
                    if (m_state == 2) begin
                        m_target = (m_mode == 2 && wait_n_i) ? 0 : m_wc;
                    end
                    if (m_tw < m_target || (m_mode == 1 && !wait_n_i)) begin
                        m_state = 3;
                        m_tw++;
                    end else begin
                        m_state = 4;
                    end
                end
                default: m_state = 0;
            endcase
        end
    end

    // Drive the wait input low while fewer than `hold` waits have run.
    always @(negedge clk) begin
        wait_n_i <= !((m_state == 2 || m_state == 3) && m_tw < hold);
    end

    // Compare outputs with the model every cycle, and wait counts at T3.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            checks++;
            if (int'(bus_state_o) != m_state) begin
                errors++;
                $display("FAIL R2/R9 state: actual %0d expected %0d", bus_state_o, m_state);
            end
            checks++;
            if (cycle_done_o != (m_state == 4)) begin
                errors++;
                $display("FAIL R7 done: actual %0b expected %0b", cycle_done_o, m_state == 4);
            end
            if (bus_state_o == 3'd2) obs_tw = 0;
            if (bus_state_o == 3'd3) obs_tw++;
            if (bus_state_o == 3'd4) begin
                checks++;
                if (obs_tw != exp_tw) begin
                    errors++;
                    $display("FAIL %s wait count: actual %0d expected %0d", tag, obs_tw, exp_tw);
                end
            end
        end
    end

    task automatic run_access(input int wc, input int mode, input int h,
                              input int exp_n, input string t, input bit scramble);
        @(negedge clk);
        wait_cnt_i = wc[WC_W-1:0];
        wait_mode_i = mode[1:0];
        hold = h;
        exp_tw = exp_n;
        tag = t;
        acc_req_i = 1'b1;
        @(negedge clk);
        acc_req_i = 1'b0;
        if (scramble) begin
            wait_cnt_i = ~wait_cnt_i;
            wait_mode_i = 2'd1;
        end
        for (int g = 0; g < 60 && bus_state_o != 3'd4; g++) @(negedge clk);
        @(negedge clk);
        checks++;
        if (bus_state_o != 3'd0) begin
            errors++;
            $display("FAIL R6 after T3: actual %0d expected 0", bus_state_o);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (bus_state_o != 3'd0 || cycle_done_o != 1'b0) begin
            errors++;
            $display("FAIL R1 reset: actual %0d/%0b expected 0/0", bus_state_o, cycle_done_o);
        end
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (bus_state_o != 3'd0) begin
            errors++;
            $display("FAIL R1 after release: actual %0d expected 0", bus_state_o);
        end
        // R3: program policy, wait input ignored.
        run_access(2, 0, 0, 2, "R3", 0);
        run_access(3, 0, 10, 3, "R3", 0);
        run_access(0, 0, 5, 0, "R3", 0);
        run_access(1, 3, 4, 1, "R3", 0);
        // R4: pin policy.
        run_access(0, 1, 0, 0, "R4", 0);
        run_access(0, 1, 3, 3, "R4", 0);
        run_access(2, 1, 1, 2, "R4", 0);
        run_access(1, 1, 6, 6, "R4", 0);
        run_access(3, 1, 3, 3, "R4", 0);
        run_access(3, 1, 4, 4, "R4", 0);
        // R5: auto policy.
        run_access(2, 2, 0, 0, "R5", 0);
        run_access(2, 2, 1, 2, "R5", 0);
        run_access(3, 2, 20, 3, "R5", 0);
        run_access(0, 2, 5, 0, "R5", 0);
        // R8: configuration changed after acceptance.
        run_access(1, 0, 9, 1, "R8", 1);
        run_access(2, 2, 0, 0, "R8", 1);
        // R2: request held high through back-to-back accesses.
        @(negedge clk);
        wait_cnt_i = 2'd1;
        wait_mode_i = 2'd0;
        hold = 0;
        exp_tw = 1;
        tag = "R2";
        acc_req_i = 1'b1;
        for (int g = 0; g < 60 && bus_state_o != 3'd4; g++) @(negedge clk);
        @(negedge clk);
        checks++;
        if (bus_state_o != 3'd0) begin
            errors++;
            $display("FAIL R2 idle gap: actual %0d expected 0", bus_state_o);
        end
        @(negedge clk);
        checks++;
        if (bus_state_o != 3'd1) begin
            errors++;
            $display("FAIL R2 restart: actual %0d expected 1", bus_state_o);
        end
        acc_req_i = 1'b0;
        repeat (10) @(negedge clk);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule